// File: doc/BRIEF.md
# Banked Control Register Unit

This unit is the control-register file of a small processor core. It holds a packed status word with its condition bit, a backup status byte, a second-level backup status byte, two backup program-counter registers and two general-purpose spare registers. All of them are reached through one write port and one combinational read port, both indexed by a control-register number.

The unit also owns the live stack pointer. Two banked copies sit beside it: one for interrupt (system) mode and one for user mode. The general register file reaches the live stack pointer through a dedicated read/write pair.

Bit 7 of the status byte selects the stack mode. A status write that flips this bit saves the live pointer into the bank being left and loads it from the bank being entered, in the same clock edge. The banked register that belongs to the active mode is an alias of the live pointer on both read and write.

Top module: `ctrl_reg_bank`

## Requirements
- R1: After reset (active-low `rst_n`), every register, the live stack pointer and both banked pointers read as zero.
- R2: Reading register 0 (status) returns zero in bits 31:16, the backup status ANDed with 0xC1 in bits 15:8, the status byte ANDed with 0xC0 in bits 7:0, and the condition bit ORed into bit 0.
- R3: Writing register 0 loads the backup status from data bits 15:8, the status byte from bits 7:0 and the condition bit from bit 0. If this write changes stack-mode bit 7 from 0 to 1, the live pointer is saved into the user bank and then reloaded from the interrupt bank.
- R4: A status write that changes bit 7 from 1 to 0 saves the live pointer into the interrupt bank and reloads it from the user bank. A status write that leaves bit 7 unchanged does not move any stack pointer.
- R5: Writing register 1 (condition) changes only the condition bit, taken from data bit 0. Reading it returns the condition bit in bit 0 and zeros elsewhere.
- R6: Registers 6 and 8 (backup PC and second backup PC) store all 32 written bits and read back with bit 0 forced to zero.
- R7: Register 2 (interrupt SP) aliases the live pointer while stack mode is 1. Register 3 (user SP) aliases the live pointer while stack mode is 0. Otherwise, each one accesses its banked copy.
- R8: Register 7 (second backup status) stores the low 8 written bits and reads back ANDed with 0xC1.
- R9: Registers 4 and 5 are plain 32-bit read/write storage with no side effects.
- R10: Register numbers 9 to 15 read as zero, and writes to them change no state.
- R11: When the stack-pointer port and the write port act in the same cycle, the port write lands first and the control-register write is applied on top of it. A swap therefore saves the port's value, and a control write to the live alias wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control-register write strobe |
| wr_addr | input | 4 | Control-register number to write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Control-register number to read |
| rd_data | output | 32 | Combinational read data |
| sp_we | input | 1 | Live stack-pointer write strobe from the register file |
| sp_wdata | input | 32 | Live stack-pointer write data |
| sp_rdata | output | 32 | Live stack-pointer value |

## Verification
The assertions assume that the inputs are known at every clock edge after reset. They also assume that a swap or alias property is judged only in cycles where `sp_we` is low; the ordering property covers the case where `sp_we` is high. The bench changes every input only on the falling edge and issues at most one control write per cycle. It raises `sp_we` together with a status write only in the dedicated ordering test, so the other properties always see the single-source case they describe.

// File: rtl/crb_pkg.sv
package crb_pkg;
    localparam int WORD_W    = 32;
    localparam int ADDR_W    = 4;
    localparam int NUM_REGS  = 9;
    localparam int STACK_BIT = 7;

    localparam logic [ADDR_W-1:0] REG_STAT  = 4'd0;
    localparam logic [ADDR_W-1:0] REG_COND  = 4'd1;
    localparam logic [ADDR_W-1:0] REG_ISP   = 4'd2;
    localparam logic [ADDR_W-1:0] REG_USP   = 4'd3;
    localparam logic [ADDR_W-1:0] REG_SPR4  = 4'd4;
    localparam logic [ADDR_W-1:0] REG_SPR5  = 4'd5;
    localparam logic [ADDR_W-1:0] REG_BPC   = 4'd6;
    localparam logic [ADDR_W-1:0] REG_BBST  = 4'd7;
    localparam logic [ADDR_W-1:0] REG_BBPC  = 4'd8;

    localparam logic [7:0] BSTAT_MASK = 8'hC1;
    localparam logic [7:0] STAT_MASK  = 8'hC0;

    typedef struct packed {
        logic [7:0]        stat;
        logic [7:0]        bstat;
        logic [7:0]        bbst;
        logic              cond;
        logic [WORD_W-1:0] sp;
        logic [WORD_W-1:0] isp;
        logic [WORD_W-1:0] usp;
        logic [WORD_W-1:0] bpc;
        logic [WORD_W-1:0] bbpc;
        logic [WORD_W-1:0] spr4;
        logic [WORD_W-1:0] spr5;
    } crb_state_t;
endpackage

// File: rtl/crb_wdecode.sv
module crb_wdecode #(
    parameter int ADDR_W   = 4,
    parameter int NUM_REGS = 9
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic [NUM_REGS-1:0] wsel
);
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
        assign wsel[i] = wr_en && (wr_addr == ADDR_W'(i));
    end
endmodule

// File: rtl/crb_sp_bank.sv
module crb_sp_bank #(
    parameter int WORD_W = 32
) (
    input  logic              sm_old,
    input  logic              sm_new,
    input  logic              stat_wr,
    input  logic              isp_wr,
    input  logic              usp_wr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [WORD_W-1:0] sp_cur,
    input  logic [WORD_W-1:0] isp_q,
    input  logic [WORD_W-1:0] usp_q,
    output logic [WORD_W-1:0] sp_d,
    output logic [WORD_W-1:0] isp_d,
    output logic [WORD_W-1:0] usp_d
);
    always_comb begin
        sp_d  = sp_cur;
        isp_d = isp_q;
        usp_d = usp_q;
        if (stat_wr && (sm_old != sm_new)) begin
            if (sm_new) begin
                usp_d = sp_cur;
                sp_d  = isp_q;
            end else begin
                isp_d = sp_cur;
                sp_d  = usp_q;
            end
        end
        if (isp_wr) begin
            if (sm_old) sp_d  = wdata;
            else        isp_d = wdata;
        end
        if (usp_wr) begin
            if (!sm_old) sp_d  = wdata;
            else         usp_d = wdata;
        end
    end
endmodule

// File: rtl/crb_rd_mux.sv
module crb_rd_mux
    import crb_pkg::*;
(
    input  crb_state_t        st,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data
);
    logic sm;
    assign sm = st.stat[STACK_BIT];

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            REG_STAT: rd_data = {{(WORD_W-16){1'b0}}, st.bstat & BSTAT_MASK,
                                 (st.stat & STAT_MASK) | {7'b0, st.cond}};
            REG_COND: rd_data = {{(WORD_W-1){1'b0}}, st.cond};
            REG_ISP:  rd_data = sm ? st.sp : st.isp;
            REG_USP:  rd_data = sm ? st.usp : st.sp;
            REG_SPR4: rd_data = st.spr4;
            REG_SPR5: rd_data = st.spr5;
            REG_BPC:  rd_data = {st.bpc[WORD_W-1:1], 1'b0};
            REG_BBST: rd_data = {{(WORD_W-8){1'b0}}, st.bbst & BSTAT_MASK};
            REG_BBPC: rd_data = {st.bbpc[WORD_W-1:1], 1'b0};
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/ctrl_reg_bank.sv
module ctrl_reg_bank
    import crb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data,
    input  logic              sp_we,
    input  logic [WORD_W-1:0] sp_wdata,
    output logic [WORD_W-1:0] sp_rdata
);
    crb_state_t          state_q, state_d;
    logic [NUM_REGS-1:0] wsel;
    logic [WORD_W-1:0]   sp_cur;
    logic [WORD_W-1:0]   sp_n, isp_n, usp_n;

    crb_wdecode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_dec (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wsel    (wsel)
    );

    // Port write lands before any control-register effect (R11)
    assign sp_cur = sp_we ? sp_wdata : state_q.sp;

    crb_sp_bank #(.WORD_W(WORD_W)) u_bank (
        .sm_old  (state_q.stat[STACK_BIT]),
        .sm_new  (wr_data[STACK_BIT]),
        .stat_wr (wsel[REG_STAT]),
        .isp_wr  (wsel[REG_ISP]),
        .usp_wr  (wsel[REG_USP]),
        .wdata   (wr_data),
        .sp_cur  (sp_cur),
        .isp_q   (state_q.isp),
        .usp_q   (state_q.usp),
        .sp_d    (sp_n),
        .isp_d   (isp_n),
        .usp_d   (usp_n)
    );

    always_comb begin
        state_d = state_q;
        if (wsel[REG_STAT]) begin
            state_d.stat  = wr_data[7:0];
            state_d.bstat = wr_data[15:8];
            state_d.cond  = wr_data[0];
        end
        if (wsel[REG_COND]) state_d.cond = wr_data[0];
        if (wsel[REG_SPR4]) state_d.spr4 = wr_data;
        if (wsel[REG_SPR5]) state_d.spr5 = wr_data;
        if (wsel[REG_BPC])  state_d.bpc  = wr_data;
        if (wsel[REG_BBST]) state_d.bbst = wr_data[7:0];
        if (wsel[REG_BBPC]) state_d.bbpc = wr_data;
        state_d.sp  = sp_n;
        state_d.isp = isp_n;
        state_d.usp = usp_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    crb_rd_mux u_rd (
        .st      (state_q),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    assign sp_rdata = state_q.sp;
endmodule

// File: rtl/crb_checker.sv
module crb_checker
    import crb_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [WORD_W-1:0] wr_data,
    input logic              sp_we,
    input logic [WORD_W-1:0] sp_wdata,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [WORD_W-1:0] rd_data,
    input crb_state_t        st
);
    logic stat_wr;
    assign stat_wr = wr_en && (wr_addr == REG_STAT);

    assert_swap_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && !st.stat[STACK_BIT] && wr_data[STACK_BIT] && !sp_we)
        |=> (st.usp == $past(st.sp)) && (st.sp == $past(st.isp)));

    assert_swap_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && st.stat[STACK_BIT] && !wr_data[STACK_BIT] && !sp_we)
        |=> (st.isp == $past(st.sp)) && (st.sp == $past(st.usp)));

    assert_no_swap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && (st.stat[STACK_BIT] == wr_data[STACK_BIT]) && !sp_we)
        |=> $stable(st.sp) && $stable(st.isp) && $stable(st.usp));

    assert_cond_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == REG_COND && !sp_we)
        |=> (st.cond == $past(wr_data[0])) && $stable(st.stat) && $stable(st.bstat) && $stable(st.sp));

    assert_bpc_even_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == REG_BPC || rd_addr == REG_BBPC) |-> !rd_data[0]);

    assert_undef_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr > REG_BBPC) |-> (rd_data == '0));

    assert_undef_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr > REG_BBPC && !sp_we) |=> $stable(st));

    assert_order_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_we && stat_wr && !st.stat[STACK_BIT] && wr_data[STACK_BIT])
        |=> (st.usp == $past(sp_wdata)));
endmodule

bind ctrl_reg_bank crb_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .sp_we    (sp_we),
    .sp_wdata (sp_wdata),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .st       (state_q)
);

// File: tb/tb_ctrl_reg_bank.sv
module tb_ctrl_reg_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        sp_we = 1'b0;
    logic [31:0] sp_wdata = '0;
    logic [31:0] sp_rdata;

    int n_tests = 0;
    int n_fail  = 0;
    bit chk_v   = 1'b0;
    bit done    = 1'b0;

    typedef struct {
        bit          from_sp;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    always #5 clk = ~clk;

    ctrl_reg_bank dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .sp_we(sp_we), .sp_wdata(sp_wdata), .sp_rdata(sp_rdata)
    );

    // Monitor: pops one expected item per flagged cycle
    always @(posedge clk) begin
        if (chk_v) begin
            item_t it;
            logic [31:0] act;
            n_tests++;
            if (sb.size() == 0) begin
                n_fail++;
                $display("FAIL scoreboard empty");
            end else begin
                it  = sb.pop_front();
                act = it.from_sp ? sp_rdata : rd_data;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic spw(input logic [31:0] d);
        sp_we = 1'b1; sp_wdata = d;
        @(negedge clk);
        sp_we = 1'b0;
    endtask

    task automatic both(input logic [3:0] a, input logic [31:0] d, input logic [31:0] s);
        wr_en = 1'b1; wr_addr = a; wr_data = d; sp_we = 1'b1; sp_wdata = s;
        @(negedge clk);
        wr_en = 1'b0; sp_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] e, input string tag);
        rd_addr = a;
        sb.push_back('{1'b0, e, tag});
        chk_v = 1'b1;
        @(negedge clk);
        chk_v = 1'b0;
    endtask

    task automatic spc(input logic [31:0] e, input string tag);
        sb.push_back('{1'b1, e, tag});
        chk_v = 1'b1;
        @(negedge clk);
        chk_v = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd(4'd0, 32'h0, "R1 status after reset");
        spc(32'h0, "R1 live sp after reset");
        rd(4'd4, 32'h0, "R1 spare4 after reset");
        rd(4'd2, 32'h0, "R1 isp after reset");

        spw(32'h0000_1000);
        wr(4'd2, 32'h0000_2000);
        rd(4'd2, 32'h0000_2000, "R7 isp banked in user mode");
        rd(4'd3, 32'h0000_1000, "R7 usp aliases live in user mode");

        wr(4'd0, 32'h0000_C181);
        spc(32'h0000_2000, "R3 live loaded from isp on 0->1");
        rd(4'd3, 32'h0000_1000, "R3 usp holds saved live");
        rd(4'd2, 32'h0000_2000, "R7 isp aliases live in system mode");
        rd(4'd0, 32'h0000_C181, "R2 status read format");

        spw(32'h0000_2468);
        wr(4'd0, 32'h0000_0000);
        spc(32'h0000_1000, "R4 live loaded from usp on 1->0");
        rd(4'd2, 32'h0000_2468, "R4 isp holds saved live");

        wr(4'd0, 32'h0000_FF7F);
        spc(32'h0000_1000, "R4 no swap when mode bit unchanged");
        rd(4'd0, 32'h0000_C141, "R2 status masks bstat and stat");

        wr(4'd1, 32'hFFFF_FFFE);
        rd(4'd1, 32'h0, "R5 cond cleared");
        rd(4'd0, 32'h0000_C140, "R5 cond write leaves status bytes");
        wr(4'd1, 32'h0000_0001);
        rd(4'd1, 32'h1, "R5 cond set");

        wr(4'd6, 32'hFFFF_FFFF);
        rd(4'd6, 32'hFFFF_FFFE, "R6 bpc bit0 forced low");
        wr(4'd8, 32'h1234_5679);
        rd(4'd8, 32'h1234_5678, "R6 bbpc bit0 forced low");

        wr(4'd7, 32'hFFFF_FFFF);
        rd(4'd7, 32'h0000_00C1, "R8 bbst masked");

        wr(4'd4, 32'hDEAD_BEEF);
        wr(4'd5, 32'h0BAD_F00D);
        rd(4'd4, 32'hDEAD_BEEF, "R9 spare4 readback");
        rd(4'd5, 32'h0BAD_F00D, "R9 spare5 readback");
        spc(32'h0000_1000, "R9 spare write leaves sp");

        wr(4'd9, 32'hFFFF_FFFF);
        wr(4'd15, 32'hFFFF_FFFF);
        rd(4'd9, 32'h0, "R10 undefined reg 9 reads zero");
        rd(4'd15, 32'h0, "R10 undefined reg 15 reads zero");
        rd(4'd4, 32'hDEAD_BEEF, "R10 undefined write left spare4");
        rd(4'd0, 32'h0000_C141, "R10 undefined write left status");
        spc(32'h0000_1000, "R10 undefined write left sp");

        both(4'd0, 32'h0000_0080, 32'h0000_5555);
        rd(4'd3, 32'h0000_5555, "R11 swap saved port value");
        spc(32'h0000_2468, "R11 live from isp after swap");
        both(4'd2, 32'h0000_7777, 32'h0000_9999);
        spc(32'h0000_7777, "R11 control write to alias wins");
        rd(4'd3, 32'h0000_5555, "R7 usp banked in system mode");

        @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule